// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by fetching two entries from page tables that sit in ordinary memory. The top ten address bits select a word in the page directory. The directory starts at the page given by a root pointer input. That directory word names the page holding a second-level table. The next ten address bits select a word in that table. The frame number found there is joined with the twelve-bit in-page offset to form the result.

All table traffic uses one 32-bit memory port with a request/acknowledge handshake, so the memory may insert any number of wait states. Software clears the referenced flag in entries to estimate which pages were used recently. Whenever the walker uses an entry whose referenced flag is clear, it writes the entry back with the flag set. A clear present flag at either level ends the walk with a fault that names the failing level, so software can bring the page in and retry.

Top module: `pt_walker`

## Requirements
- R1: During and right after reset, `busy`, `mem_req`, `done` and `fault` are low.
- R2: The first read of a walk targets `{dir_base[31:12], 12'h000} + 4*lin[31:22]`; bits 11:0 of `dir_base` have no effect.
- R3: The second read targets `{pde[31:12], 12'h000} + 4*lin[21:12]`, where `pde` is the directory word just read.
- R4: On success `done` pulses for exactly one cycle, and `phys_addr` equals `{pte[31:12], lin[11:0]}`. It holds that value until the next request is accepted.
- R5: If bit 0 (present) of the directory word is 0, the walk ends with `fault` high and `fault_level` = 0, with no table read and no write.
- R6: If bit 0 of the table word is 0, the walk ends with `fault` high and `fault_level` = 1, and no write is made.
- R7: When a used entry has bit 5 (referenced) clear, the walker writes that entry, with bit 5 set and all other bits unchanged, back to the address it came from before moving on. When bit 5 is already set, no write is made.
- R8: `req_valid` is ignored while `busy` is high. A request raised during a walk neither changes its result nor starts another walk.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` stay stable, so any number of wait states is tolerated.
- R10: Each accepted request ends with exactly one pulse of either `done` or `fault`, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a translation (accepted when idle) |
| req_lin_addr | input | 32 | Linear address to translate |
| dir_base | input | 32 | Root pointer; bits 31:12 give the directory page |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value written back |
| mem_rdata | input | 32 | Entry value returned with `mem_ack` |
| mem_ack | input | 1 | Access completed this cycle |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: entry not present |
| fault_level | output | 1 | 0 = directory, 1 = second-level table |
| phys_addr | output | 32 | Translated physical address |

## Verification
A corrupted state register or entry register shows within one access at `mem_addr`. The second read or the write-back lands on the wrong word, and the bench logs those addresses against the ones it derives from the table contents. A wrong present or referenced decision shows up as a missing or extra write, or as a wrong fault level, in the walk where it happens. The bench's memory model then keeps the bad entry contents, so the next walk that uses the same entry exposes it again. Wait states are inserted so that an address that drifts before acknowledge reaches the wrong word.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        WK_IDLE     = 3'd0,
        WK_DIR_RD   = 3'd1,
        WK_DIR_MARK = 3'd2,
        WK_TBL_RD   = 3'd3,
        WK_TBL_MARK = 3'd4,
        WK_DONE     = 3'd5,
        WK_FAULT    = 3'd6
    } walk_state_e;

    localparam int unsigned LEVELS = 2;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned OFF_W  = 12
) (
    input  logic [ADDR_W-OFF_W-1:0] base_page,
    input  logic [IDX_W-1:0]        index,
    output logic [ADDR_W-1:0]       entry_addr
);
    localparam int unsigned ENTRY_BYTES = ADDR_W / 8;
    localparam int unsigned ENTRY_SHIFT = $clog2(ENTRY_BYTES);

    logic [ADDR_W-1:0] page_start;
    logic [ADDR_W-1:0] byte_offset;

    assign page_start  = {base_page, {OFF_W{1'b0}}};
    assign byte_offset = ADDR_W'(index) << ENTRY_SHIFT;
    assign entry_addr  = page_start + byte_offset;
endmodule

// File: rtl/pt_entry_fields.sv
module pt_entry_fields #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned OFF_W       = 12,
    parameter int unsigned PRESENT_BIT = 0,
    parameter int unsigned REF_BIT     = 5
) (
    input  logic [ADDR_W-1:0]       entry,
    output logic                    present,
    output logic                    referenced,
    output logic [ADDR_W-OFF_W-1:0] page,
    output logic [ADDR_W-1:0]       marked
);
    assign present    = entry[PRESENT_BIT];
    assign referenced = entry[REF_BIT];
    assign page       = entry[ADDR_W-1:OFF_W];
    assign marked     = entry | (ADDR_W'(1) << REF_BIT);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned IDX_W       = 10,
    parameter int unsigned OFF_W       = 12,
    parameter int unsigned PRESENT_BIT = 0,
    parameter int unsigned REF_BIT     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_lin_addr,
    input  logic [ADDR_W-1:0] dir_base,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              done,
    output logic              fault,
    output logic              fault_level,
    output logic [ADDR_W-1:0] phys_addr
);
    import pt_walker_pkg::*;

    localparam int unsigned PAGE_W = ADDR_W - OFF_W;

    typedef struct packed {
        walk_state_e       st;
        logic [ADDR_W-1:0] lin;
        logic [PAGE_W-1:0] root;
        logic [ADDR_W-1:0] dir_ent;
        logic [ADDR_W-1:0] tbl_ent;
        logic [ADDR_W-1:0] pa;
        logic              flevel;
    } walk_regs_t;

    walk_regs_t q, d;

    // per-level entry storage, table base, index and derived addresses
    logic [ADDR_W-1:0] lvl_entry  [LEVELS];
    logic [PAGE_W-1:0] lvl_base   [LEVELS];
    logic [PAGE_W-1:0] lvl_page   [LEVELS];
    logic [IDX_W-1:0]  lvl_idx    [LEVELS];
    logic [ADDR_W-1:0] lvl_addr   [LEVELS];
    logic [ADDR_W-1:0] lvl_marked [LEVELS];
    logic              lvl_present[LEVELS];
    logic              lvl_ref    [LEVELS];

    assign lvl_entry[0] = q.dir_ent;
    assign lvl_entry[1] = q.tbl_ent;
    assign lvl_base[0]  = q.root;
    assign lvl_base[1]  = lvl_page[0];

    genvar g;
    generate
        for (g = 0; g < LEVELS; g++) begin : g_level
            assign lvl_idx[g] = q.lin[ADDR_W-1-g*IDX_W -: IDX_W];

            pt_entry_addr #(
                .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
            ) u_addr (
                .base_page (lvl_base[g]),
                .index     (lvl_idx[g]),
                .entry_addr(lvl_addr[g])
            );

            pt_entry_fields #(
                .ADDR_W(ADDR_W), .OFF_W(OFF_W),
                .PRESENT_BIT(PRESENT_BIT), .REF_BIT(REF_BIT)
            ) u_fields (
                .entry     (lvl_entry[g]),
                .present   (lvl_present[g]),
                .referenced(lvl_ref[g]),
                .page      (lvl_page[g]),
                .marked    (lvl_marked[g])
            );
        end
    endgenerate

    // decode of the word returned by memory
    logic              rd_present;
    logic              rd_ref;
    logic [PAGE_W-1:0] rd_page;
    logic [ADDR_W-1:0] rd_marked;

    pt_entry_fields #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W),
        .PRESENT_BIT(PRESENT_BIT), .REF_BIT(REF_BIT)
    ) u_rd_fields (
        .entry     (mem_rdata),
        .present   (rd_present),
        .referenced(rd_ref),
        .page      (rd_page),
        .marked    (rd_marked)
    );

    // stored-entry flags are only informative; the decision uses the fresh word
    logic unused_flags;
    assign unused_flags = lvl_present[0] ^ lvl_present[1] ^ lvl_ref[0] ^ lvl_ref[1]
                        ^ (^lvl_page[1]) ^ (^rd_marked);

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;

        unique case (q.st)
            WK_IDLE: begin
                if (req_valid) begin
                    d.lin  = req_lin_addr;
                    d.root = dir_base[ADDR_W-1:OFF_W];
                    d.st   = WK_DIR_RD;
                end
            end
            WK_DIR_RD: begin
                mem_req  = 1'b1;
                mem_addr = lvl_addr[0];
                if (mem_ack) begin
                    d.dir_ent = mem_rdata;
                    if (!rd_present) begin
                        d.flevel = 1'b0;
                        d.st     = WK_FAULT;
                    end else if (!rd_ref) begin
                        d.st = WK_DIR_MARK;
                    end else begin
                        d.st = WK_TBL_RD;
                    end
                end
            end
            WK_DIR_MARK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = lvl_addr[0];
                mem_wdata = lvl_marked[0];
                if (mem_ack) d.st = WK_TBL_RD;
            end
            WK_TBL_RD: begin
                mem_req  = 1'b1;
                mem_addr = lvl_addr[1];
                if (mem_ack) begin
                    d.tbl_ent = mem_rdata;
                    if (!rd_present) begin
                        d.flevel = 1'b1;
                        d.st     = WK_FAULT;
                    end else begin
                        d.pa = {rd_page, q.lin[OFF_W-1:0]};
                        d.st = rd_ref ? WK_DONE : WK_TBL_MARK;
                    end
                end
            end
            WK_TBL_MARK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = lvl_addr[1];
                mem_wdata = lvl_marked[1];
                if (mem_ack) d.st = WK_DONE;
            end
            WK_DONE:  d.st = WK_IDLE;
            WK_FAULT: d.st = WK_IDLE;
            default:  d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.st != WK_IDLE);
    assign done        = (q.st == WK_DONE);
    assign fault       = (q.st == WK_FAULT);
    assign fault_level = q.flevel;
    assign phys_addr   = q.pa;
endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned PRESENT_BIT = 0,
    parameter int unsigned REF_BIT     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              done,
    input logic              fault
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_req && !done && !fault));

    assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_mark_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[REF_BIT] && mem_wdata[PRESENT_BIT]));

    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fault_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);
endmodule

bind pt_walker pt_walker_checker #(
    .ADDR_W(ADDR_W), .PRESENT_BIT(PRESENT_BIT), .REF_BIT(REF_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .done(done), .fault(fault)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin_addr = '0;
    logic [31:0] dir_base = '0;
    logic        busy, mem_req, mem_we, done, fault, fault_level;
    logic [31:0] mem_addr, mem_wdata, phys_addr;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;

    always #2.5 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin_addr(req_lin_addr),
        .dir_base(dir_base), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .done(done), .fault(fault), .fault_level(fault_level),
        .phys_addr(phys_addr)
    );

    // memory model: 16 KB, configurable wait states, logs accesses
    logic [31:0] mem [4096];
    int unsigned lat = 0;
    int unsigned wcnt = 0;
    int unsigned rd_cnt = 0;
    int unsigned wr_cnt = 0;
    logic [31:0] rd_log [4];
    logic        clr_log = 1'b0;

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (clr_log) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
        end
        if (mem_req && !mem_ack) begin
            if (wcnt >= lat) begin
                wcnt      <= 0;
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[13:2]];
                if (mem_we) begin
                    mem[mem_addr[13:2]] <= mem_wdata;
                    if (!clr_log) wr_cnt <= wr_cnt + 1;
                end else if (!clr_log) begin
                    if (rd_cnt < 4) rd_log[rd_cnt] <= mem_addr;
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic        got_done, got_fault, got_lvl;
    logic [31:0] got_pa;
    int unsigned n_done, n_fault;

    task automatic walk(input logic [31:0] base, input logic [31:0] lin, input int unsigned noise);
        @(negedge clk);
        clr_log = 1'b1;
        @(negedge clk);
        clr_log = 1'b0;
        dir_base = base;
        req_lin_addr = lin;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (noise != 0) begin
            req_lin_addr = 32'h0080_0000;
            req_valid = 1'b1;
            for (int i = 0; i < int'(noise); i++) @(negedge clk);
            req_valid = 1'b0;
        end
        got_done = 0; got_fault = 0; got_lvl = 0; got_pa = '0;
        n_done = 0; n_fault = 0;
        for (int i = 0; i < 300; i++) begin
            if (done)  begin n_done++;  got_done = 1; got_pa = phys_addr; end
            if (fault) begin n_fault++; got_fault = 1; got_lvl = fault_level; end
            if ((got_done || got_fault) && !busy && i > 2) break;
            @(negedge clk);
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (done) n_done++;
            if (fault) n_fault++;
        end
    endtask

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] lin;
        logic        exp_fault;
        logic        exp_lvl;
        logic [31:0] exp_pa;
        logic [3:0]  exp_wr;
        logic [3:0]  exp_rd;
        logic [31:0] exp_tbl;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 32'h0000_0ABC, 1'b0, 1'b0, 32'hABCD_EABC, 4'd2, 4'd2, 32'h0000_1000},
        '{32'h0000_0000, 32'h0000_3123, 1'b0, 1'b0, 32'h1234_5123, 4'd0, 4'd2, 32'h0000_100C},
        '{32'h0000_0000, 32'h0000_5000, 1'b1, 1'b1, 32'h0000_0000, 4'd0, 4'd2, 32'h0000_1014},
        '{32'h0000_0000, 32'h0080_0000, 1'b1, 1'b0, 32'h0000_0000, 4'd0, 4'd1, 32'h0000_0000},
        '{32'h0000_0FFF, 32'h007F_FFFF, 1'b0, 1'b0, 32'hFFFF_FFFF, 4'd0, 4'd2, 32'h0000_2FFC},
        '{32'h0000_0123, 32'h0000_0ABC, 1'b0, 1'b0, 32'hABCD_EABC, 4'd0, 4'd2, 32'h0000_1000}
    };

    initial begin
        #500us;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        // directory at 0x0000: entry0 present/unreferenced, entry1 present/referenced, entry2 absent
        mem[0]     = 32'h0000_1001;
        mem[1]     = 32'h0000_2021;
        mem[2]     = 32'h0000_3000;
        // table at 0x1000
        mem[1024]  = 32'hABCD_E001;
        mem[1027]  = 32'h1234_5021;
        mem[1029]  = 32'h0000_0000;
        // table at 0x2000
        mem[3071]  = 32'hFFFF_F021;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy",    {31'd0, busy},    32'd0);
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
        check("R1 done",    {31'd0, done},    32'd0);
        check("R1 fault",   {31'd0, fault},   32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            walk(VECS[v].base, VECS[v].lin, 0);
            check($sformatf("R5/R6 fault v%0d", v), {31'd0, got_fault}, {31'd0, VECS[v].exp_fault});
            check($sformatf("R10 outcomes v%0d", v), n_done + n_fault, 32'd1);
            if (VECS[v].exp_fault)
                check($sformatf("R5/R6 level v%0d", v), {31'd0, got_lvl}, {31'd0, VECS[v].exp_lvl});
            else
                check($sformatf("R4 phys_addr v%0d", v), got_pa, VECS[v].exp_pa);
            check($sformatf("R7 writes v%0d", v), wr_cnt, {28'd0, VECS[v].exp_wr});
            check($sformatf("R5 reads v%0d", v), rd_cnt, {28'd0, VECS[v].exp_rd});
            check($sformatf("R2 dir addr v%0d", v), rd_log[0],
                  {VECS[v].base[31:12], 12'h000} + {20'd0, VECS[v].lin[31:22], 2'b00});
            if (VECS[v].exp_rd == 4'd2)
                check($sformatf("R3 table addr v%0d", v), rd_log[1], VECS[v].exp_tbl);
            if (v == 0) begin
                check("R7 dir entry marked",   mem[0],    32'h0000_1021);
                check("R7 table entry marked", mem[1024], 32'hABCD_E021);
            end
        end

        // R4: result held after done
        repeat (3) @(negedge clk);
        check("R4 phys_addr held", phys_addr, 32'hABCD_EABC);

        // R8: requests raised during a walk are ignored
        walk(32'h0, 32'h0000_3123, 2);
        check("R8 result", got_pa, 32'h1234_5123);
        check("R8 single outcome", n_done + n_fault, 32'd1);
        check("R8 idle after", {31'd0, busy}, 32'd0);
        check("R8 reads", rd_cnt, 32'd2);

        // R9: wait states
        lat = 3;
        walk(32'h0, 32'h007F_F234, 0);
        check("R9 phys_addr with waits", got_pa, 32'hFFFF_F234);
        check("R9 table addr with waits", rd_log[1], 32'h0000_2FFC);

        // R7 with wait states: fresh unreferenced entries, both marked
        mem[3]    = 32'h0000_1001;
        mem[1030] = 32'h0BAD_0001;
        walk(32'h0, 32'h00C0_6777, 0);
        check("R7 writes with waits", wr_cnt, 32'd2);
        check("R7 marked pde", mem[3], 32'h0000_1021);
        check("R7 marked pte", mem[1030], 32'h0BAD_0021);
        check("R4 phys_addr after mark", got_pa, 32'h0BAD_0777);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule